// File: doc/BRIEF.md
# Asynchronous SRAM Timing Controller

This block turns single-word requests from a synchronous host into correctly timed strobe sequences for an external asynchronous static RAM. The RAM has a 19-bit word address and a 16-bit data bus split into two byte lanes. The controller owns every memory-side pin: a pair of chip selects of opposite polarity, an output enable, a write enable, one active-low enable per byte lane, the address, and a shared data bus. The shared bus appears as separate outbound data, inbound data and drive-enable signals. Each pin is driven from a flop, so no strobe can glitch.

The RAM has no clock, so the controller enforces its timing minimums by counting clock cycles. Each count is derived at elaboration time from a nanosecond minimum and the clock-period parameter. The count is the ceiling of the quotient, and never less than one cycle. A read holds address, selects and output enable for the read count, captures the data bus on the final edge, and then waits out the time the RAM takes to float its outputs. A write lowers write enable for the pulse count while driving data. It then raises write enable first and holds the selects, lane enables and data for the remainder of the write-cycle count.

The host side is a valid/ready stream. `req_ready` is high only when no access is in flight. A request transfers on a rising edge where `req_valid` and `req_ready` are both high. The host must hold its request fields until that edge. Read results come back on `rd_valid` as a one-cycle strobe with no back-pressure. The host must take each result in the cycle it appears.

Top module: `sram_timing_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the following clock cycle shows all memory strobes inactive (`mem_ce1_n`=1, `mem_ce2`=0, `mem_oe_n`=1, `mem_we_n`=1, every `mem_be_n` bit 1), `mem_dq_oe`=0 and `req_ready`=1.
- R2: `req_ready` is high exactly when the controller is idle. It drops in the cycle after a request with a nonzero mask is taken, and stays low until that access, including its recovery, is complete.
- R3: During a read, `mem_ce1_n`=0, `mem_ce2`=1, `mem_oe_n`=0 and `mem_we_n`=1. `mem_be_n[0]` equals the inverse of `req_mask[0]` and gates data bits 7:0. `mem_be_n[1]` equals the inverse of `req_mask[1]` and gates bits 15:8. The bus is not driven.
- R4: A read keeps its pins steady for RD = max(ceil(55 ns / period), ceil(55 ns / period)) cycles, with a minimum of 1. It samples the bus on the last of those edges, so `rd_valid` is seen RD+1 falling edges after acceptance. `rd_valid` is a single-cycle pulse, and byte lanes not enabled return 0x00.
- R5: A write drives `mem_we_n`=0 with the selects active, `mem_oe_n`=1, the lane enables from the mask and `mem_dq_oe`=1 carrying the write data. The low pulse lasts WE = ceil(max(35, 35, 35, 25) ns / period) cycles, with a minimum of 1.
- R6: A write ends when `mem_we_n` rises. Selects, lane enables, address and data stay asserted for max(1, ceil(55 ns / period) − WE) more cycles, and then all are released together.
- R7: The bus is never driven while `mem_oe_n` is low. It is not driven in the cycle after `mem_oe_n` rises, and it stays undriven until at least ceil(18 ns / period) cycles have passed.
- R8: A request with an all-zero mask is taken without asserting any strobe, and `req_ready` stays high. A write with a zero mask has no effect. A read with a zero mask produces one `rd_valid` pulse in the next cycle, with data 0x0000.
- R9: Read data returns, lane by lane, the bytes last written to that address by writes whose mask enabled the lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all timing counts are in its periods |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller idle and able to take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| req_mask | input | DATA_W/8 | Byte-lane mask, bit 0 = bits 7:0 |
| rd_valid | output | 1 | One-cycle strobe with read result |
| rd_data | output | DATA_W | Read result, disabled lanes zero |
| mem_ce1_n | output | 1 | Chip select, active low |
| mem_ce2 | output | 1 | Chip select, active high |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_be_n | output | DATA_W/8 | Per-lane enables, active low, bit 0 = lower byte |
| mem_addr | output | ADDR_W | Memory address |
| mem_dq_out | output | DATA_W | Data driven onto the bus |
| mem_dq_in | input | DATA_W | Data seen on the bus |
| mem_dq_oe | output | 1 | Controller drives the bus |

## Verification
The properties assume that reset is held over at least one rising edge before any traffic, and that every derived count is at least one cycle, which the count formula guarantees. They place no limit on how often requests arrive: `req_valid` may stay high across back-to-back accesses, and its fields may change only while `req_ready` is low. The stimulus changes request fields only on falling edges and waits for `req_ready` before each request. It draws masks from all four codes, addresses from both ends of the space and a small pool so that reads hit earlier writes, and it builds RAM-side data only from the pin activity at the controller's ports.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ,
    ST_TURN,
    ST_WLOW,
    ST_WREC
  } ctl_state_e;

  // Whole cycles covering a minimum time, never fewer than one.
  function automatic int unsigned span_cycles(input int unsigned ns, input int unsigned period_ns);
    int unsigned c;
    c = (ns + period_ns - 1) / period_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
`timescale 1ns/1ps
module asram_timer #(
  parameter int unsigned CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          last
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (load)
      cnt_q <= load_val;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - 1'b1;
  end

  // High during the final cycle of a loaded interval.
  assign last = (cnt_q == CW'(1));

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W  = 19,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned LANES   = 2,
  parameter int unsigned CW      = 3,
  parameter int unsigned RD_CYC  = 3,
  parameter int unsigned WE_CYC  = 2,
  parameter int unsigned REC_CYC = 1,
  parameter int unsigned HZ_CYC  = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [LANES-1:0]  req_mask,
  output logic              req_ready,
  input  logic              tmr_last,
  output logic              tmr_load,
  output logic [CW-1:0]     tmr_val,
  output logic              sample,
  output logic              zero_rd,
  output logic              sel_act,
  output logic              oe_act,
  output logic              we_act,
  output logic [LANES-1:0]  lane_act,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe
);

  ctl_state_e        st_q, st_d;
  logic              sel_q, sel_d;
  logic              oe_q, oe_d;
  logic              we_q, we_d;
  logic [LANES-1:0]  lane_q, lane_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] dq_q, dq_d;
  logic              dqoe_q, dqoe_d;

  always_comb begin
    st_d     = st_q;
    sel_d    = sel_q;
    oe_d     = oe_q;
    we_d     = we_q;
    lane_d   = lane_q;
    addr_d   = addr_q;
    dq_d     = dq_q;
    dqoe_d   = dqoe_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    sample   = 1'b0;
    zero_rd  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (req_valid) begin
          if (req_mask == '0) begin
            zero_rd = ~req_write;
          end else if (req_write) begin
            st_d     = ST_WLOW;
            tmr_load = 1'b1;
            tmr_val  = CW'(WE_CYC);
            sel_d    = 1'b1;
            we_d     = 1'b1;
            lane_d   = req_mask;
            addr_d   = req_addr;
            dq_d     = req_wdata;
            dqoe_d   = 1'b1;
          end else begin
            st_d     = ST_READ;
            tmr_load = 1'b1;
            tmr_val  = CW'(RD_CYC);
            sel_d    = 1'b1;
            oe_d     = 1'b1;
            lane_d   = req_mask;
            addr_d   = req_addr;
          end
        end
      end
      ST_READ: begin
        if (tmr_last) begin
          sample   = 1'b1;
          st_d     = ST_TURN;
          tmr_load = 1'b1;
          tmr_val  = CW'(HZ_CYC);
          sel_d    = 1'b0;
          oe_d     = 1'b0;
          lane_d   = '0;
        end
      end
      ST_TURN: begin
        if (tmr_last) st_d = ST_IDLE;
      end
      ST_WLOW: begin
        if (tmr_last) begin
          we_d     = 1'b0;
          st_d     = ST_WREC;
          tmr_load = 1'b1;
          tmr_val  = CW'(REC_CYC);
        end
      end
      ST_WREC: begin
        if (tmr_last) begin
          sel_d  = 1'b0;
          lane_d = '0;
          dqoe_d = 1'b0;
          st_d   = ST_IDLE;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      sel_q  <= 1'b0;
      oe_q   <= 1'b0;
      we_q   <= 1'b0;
      lane_q <= '0;
      addr_q <= '0;
      dq_q   <= '0;
      dqoe_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      sel_q  <= sel_d;
      oe_q   <= oe_d;
      we_q   <= we_d;
      lane_q <= lane_d;
      addr_q <= addr_d;
      dq_q   <= dq_d;
      dqoe_q <= dqoe_d;
    end
  end

  assign req_ready = (st_q == ST_IDLE);
  assign sel_act   = sel_q;
  assign oe_act    = oe_q;
  assign we_act    = we_q;
  assign lane_act  = lane_q;
  assign addr      = addr_q;
  assign dq_out    = dq_q;
  assign dq_oe     = dqoe_q;

endmodule

// File: rtl/asram_rdlanes.sv
`timescale 1ns/1ps
module asram_rdlanes #(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LANES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sample,
  input  logic              zero_rd,
  input  logic [LANES-1:0]  lane_act,
  input  logic [DATA_W-1:0] dq_in,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  logic vld_q;

  always_ff @(posedge clk) begin
    if (rst) vld_q <= 1'b0;
    else     vld_q <= sample | zero_rd;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst)
        byte_q <= 8'h00;
      else if (sample || zero_rd)
        byte_q <= (sample && lane_act[i]) ? dq_in[8*i +: 8] : 8'h00;
    end
    assign rd_data[8*i +: 8] = byte_q;
  end

  assign rd_valid = vld_q;

endmodule

// File: rtl/sram_timing_ctrl.sv
`timescale 1ns/1ps
module sram_timing_ctrl
  import asram_pkg::*;
#(
  parameter int unsigned ADDR_W        = 19,
  parameter int unsigned DATA_W        = 16,
  parameter int unsigned CLK_PERIOD_NS = 20,
  parameter int unsigned T_RC_NS       = 55,
  parameter int unsigned T_AA_NS       = 55,
  parameter int unsigned T_WC_NS       = 55,
  parameter int unsigned T_PWE_NS      = 35,
  parameter int unsigned T_SCE_NS      = 35,
  parameter int unsigned T_AW_NS       = 35,
  parameter int unsigned T_SD_NS       = 25,
  parameter int unsigned T_HZOE_NS     = 18
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  req_valid,
  output logic                  req_ready,
  input  logic                  req_write,
  input  logic [ADDR_W-1:0]     req_addr,
  input  logic [DATA_W-1:0]     req_wdata,
  input  logic [DATA_W/8-1:0]   req_mask,
  output logic                  rd_valid,
  output logic [DATA_W-1:0]     rd_data,
  output logic                  mem_ce1_n,
  output logic                  mem_ce2,
  output logic                  mem_oe_n,
  output logic                  mem_we_n,
  output logic [DATA_W/8-1:0]   mem_be_n,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [DATA_W-1:0]     mem_dq_out,
  input  logic [DATA_W-1:0]     mem_dq_in,
  output logic                  mem_dq_oe
);

  localparam int unsigned LANES   = DATA_W / 8;
  localparam int unsigned RD_CYC  = max2(span_cycles(T_RC_NS, CLK_PERIOD_NS),
                                         span_cycles(T_AA_NS, CLK_PERIOD_NS));
  localparam int unsigned WE_CYC  = max2(max2(span_cycles(T_PWE_NS, CLK_PERIOD_NS),
                                              span_cycles(T_SCE_NS, CLK_PERIOD_NS)),
                                         max2(span_cycles(T_AW_NS, CLK_PERIOD_NS),
                                              span_cycles(T_SD_NS, CLK_PERIOD_NS)));
  localparam int unsigned WC_CYC  = span_cycles(T_WC_NS, CLK_PERIOD_NS);
  localparam int unsigned REC_CYC = (WC_CYC > WE_CYC) ? (WC_CYC - WE_CYC) : 1;
  localparam int unsigned HZ_CYC  = span_cycles(T_HZOE_NS, CLK_PERIOD_NS);
  localparam int unsigned MAX_CYC = max2(max2(RD_CYC, WE_CYC), max2(REC_CYC, HZ_CYC));
  localparam int unsigned CW      = $clog2(MAX_CYC + 1);

  logic             tmr_load;
  logic [CW-1:0]    tmr_val;
  logic             tmr_last;
  logic             sample;
  logic             zero_rd;
  logic             sel_act;
  logic             oe_act;
  logic             we_act;
  logic [LANES-1:0] lane_act;

  asram_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .last     (tmr_last)
  );

  asram_seq #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .LANES   (LANES),
    .CW      (CW),
    .RD_CYC  (RD_CYC),
    .WE_CYC  (WE_CYC),
    .REC_CYC (REC_CYC),
    .HZ_CYC  (HZ_CYC)
  ) u_seq (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .req_wdata (req_wdata),
    .req_mask  (req_mask),
    .req_ready (req_ready),
    .tmr_last  (tmr_last),
    .tmr_load  (tmr_load),
    .tmr_val   (tmr_val),
    .sample    (sample),
    .zero_rd   (zero_rd),
    .sel_act   (sel_act),
    .oe_act    (oe_act),
    .we_act    (we_act),
    .lane_act  (lane_act),
    .addr      (mem_addr),
    .dq_out    (mem_dq_out),
    .dq_oe     (mem_dq_oe)
  );

  asram_rdlanes #(.DATA_W(DATA_W), .LANES(LANES)) u_lanes (
    .clk      (clk),
    .rst      (rst),
    .sample   (sample),
    .zero_rd  (zero_rd),
    .lane_act (lane_act),
    .dq_in    (mem_dq_in),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  // Both selects come from one flop, so they switch together.
  assign mem_ce1_n = ~sel_act;
  assign mem_ce2   = sel_act;
  assign mem_oe_n  = ~oe_act;
  assign mem_we_n  = ~we_act;
  assign mem_be_n  = ~lane_act;

endmodule

// File: rtl/asram_ctl_checker.sv
`timescale 1ns/1ps
module asram_ctl_checker #(
  parameter int unsigned ADDR_W = 19,
  parameter int unsigned LANES  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [LANES-1:0]  req_mask,
  input logic              mem_ce1_n,
  input logic              mem_ce2,
  input logic              mem_oe_n,
  input logic              mem_we_n,
  input logic [LANES-1:0]  mem_be_n,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_dq_oe
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (mem_ce1_n && !mem_ce2 && mem_oe_n && mem_we_n && (&mem_be_n) && !mem_dq_oe && req_ready));

  a_r2_idle_no_strobe: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_we_n && mem_oe_n && !mem_dq_oe));

  a_r2_busy_after_take: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_mask != '0)) |=> !req_ready);

  a_r3_read_strobes: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (mem_we_n && !mem_ce1_n && mem_ce2 && !(&mem_be_n) && !mem_dq_oe));

  a_r5_write_drive: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_dq_oe && !mem_ce1_n && mem_ce2 && mem_oe_n && !(&mem_be_n)));

  a_r6_we_ends_first: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_ce1_n && mem_ce2 && mem_dq_oe && $stable(mem_addr) && $stable(mem_be_n)));

  a_r7_turnaround: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_oe_n) |=> !mem_dq_oe);

  a_r8_zero_mask_quiet: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && (req_mask == '0)) |=> (mem_ce1_n && mem_we_n && mem_oe_n && req_ready));

endmodule

bind sram_timing_ctrl asram_ctl_checker #(.ADDR_W(ADDR_W), .LANES(DATA_W/8)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_mask  (req_mask),
  .mem_ce1_n (mem_ce1_n),
  .mem_ce2   (mem_ce2),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_be_n  (mem_be_n),
  .mem_addr  (mem_addr),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sim_sram_timing_ctrl.sv
`timescale 1ns/1ps
module sim_sram_timing_ctrl;

  localparam int AW  = 19;
  localparam int DW  = 16;
  localparam int NL  = 2;
  localparam int PER = 20;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction

  localparam int RDC  = cyc(55);
  localparam int WEC  = cyc(35);
  localparam int WCC  = cyc(55);
  localparam int RECC = (WCC > WEC) ? WCC - WEC : 1;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [NL-1:0] req_mask = '0;
  logic          req_ready, rd_valid;
  logic [DW-1:0] rd_data;
  logic          mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [NL-1:0] mem_be_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dq_out;
  logic [DW-1:0] mem_dq_in = 16'hDEAD;

  always #(PER/2) clk = ~clk;

  sram_timing_ctrl #(.CLK_PERIOD_NS(PER)) u0 (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rd_valid(rd_valid), .rd_data(rd_data),
    .mem_ce1_n(mem_ce1_n), .mem_ce2(mem_ce2), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  // RAM model built from pin activity; each change is dated at the edge before this falling edge.
  logic [DW-1:0] model_mem [logic [AW-1:0]];
  logic [DW-1:0] ref_mem   [logic [AW-1:0]];
  time t_start = 0, t_addr = 0, t_rel = 0, t_wef = 0, t_dq = 0;
  logic p_ce1 = 1, p_ce2 = 0, p_oe = 1, p_we = 1, p_dqoe = 0, p_drv = 0, p_sel = 0, wr_open = 0;
  logic [NL-1:0] p_be = '1;
  logic [AW-1:0] p_addr = '0;
  logic [DW-1:0] p_dq = '0;

  always @(negedge clk) begin
    logic sel, drv;
    logic [DW-1:0] w;
    time te;
    te  = $time - PER/2;
    sel = !mem_ce1_n && mem_ce2 && !(&mem_be_n);
    drv = sel && !mem_oe_n && mem_we_n;
    if (!rst) begin
      if (mem_addr != p_addr) t_addr = te;
      if (mem_addr != p_addr || mem_ce1_n != p_ce1 || mem_ce2 != p_ce2 ||
          mem_oe_n != p_oe || mem_be_n != p_be) t_start = te;
      if (p_drv && !drv) t_rel = te;
      if (p_we && !mem_we_n) begin t_wef = te; wr_open = 1; end
      if (!p_we && mem_we_n && p_sel) begin
        check(te - t_wef >= 35, "R5", "write pulse ns", 32'(te - t_wef), 32'd35);
        check(te - t_dq >= 25, "R5", "data setup ns", 32'(te - t_dq), 32'd25);
        check(te - t_addr >= 35, "R5", "address setup ns", 32'(te - t_addr), 32'd35);
        check(p_dqoe == 1'b1, "R5", "bus driven at write end", 32'(p_dqoe), 32'd1);
        w = model_mem.exists(p_addr) ? model_mem[p_addr] : 16'h0000;
        if (!p_be[0]) w[7:0]  = p_dq[7:0];
        if (!p_be[1]) w[15:8] = p_dq[15:8];
        model_mem[p_addr] = w;
      end
      if (p_sel && !sel && wr_open) begin
        check(te - t_wef >= 55, "R6", "write cycle ns", 32'(te - t_wef), 32'd55);
        wr_open = 0;
      end
      if (mem_dq_out != p_dq) t_dq = te;
      if (mem_dq_oe && drv)
        check(1'b0, "R7", "bus contention", 32'd1, 32'd0);
      if (mem_dq_oe && !p_dqoe)
        check(te - t_rel >= 18, "R7", "turnaround ns", 32'(te - t_rel), 32'd18);
      if (drv && ($time + PER/2 - t_start >= 55)) begin
        w = model_mem.exists(mem_addr) ? model_mem[mem_addr] : 16'h0000;
        mem_dq_in = {mem_be_n[1] ? 8'hA5 : w[15:8], mem_be_n[0] ? 8'h5A : w[7:0]};
      end else begin
        mem_dq_in = 16'hDEAD;
      end
    end
    p_ce1 = mem_ce1_n; p_ce2 = mem_ce2; p_oe = mem_oe_n; p_we = mem_we_n;
    p_be = mem_be_n; p_addr = mem_addr; p_dq = mem_dq_out; p_dqoe = mem_dq_oe;
    p_drv = drv; p_sel = sel;
  end

  function automatic logic [DW-1:0] expect_rd(input logic [AW-1:0] a, input logic [NL-1:0] m);
    logic [DW-1:0] v;
    v = ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
    return {m[1] ? v[15:8] : 8'h00, m[0] ? v[7:0] : 8'h00};
  endfunction

  task automatic do_req(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [NL-1:0] m);
    int n;
    logic [DW-1:0] ev, w;
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = a; req_wdata = d; req_mask = m;
    @(negedge clk);
    req_valid = 0;
    if (m == '0) begin
      check(req_ready == 1'b1, "R8", "ready kept", 32'(req_ready), 32'd1);
      check(mem_ce1_n && mem_we_n && mem_oe_n, "R8", "no strobe",
            {29'd0, mem_ce1_n, mem_we_n, mem_oe_n}, 32'd7);
      if (!wr) begin
        check(rd_valid == 1'b1, "R8", "zero-mask read pulse", 32'(rd_valid), 32'd1);
        check(rd_data == 16'h0000, "R8", "zero-mask read data", 32'(rd_data), 32'd0);
      end else begin
        check(rd_valid == 1'b0, "R8", "no pulse on write", 32'(rd_valid), 32'd0);
      end
    end else if (!wr) begin
      check(req_ready == 1'b0, "R2", "busy during read", 32'(req_ready), 32'd0);
      check({mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe} ==
            {1'b0, 1'b1, 1'b0, 1'b1, ~m, 1'b0}, "R3", "read pins",
            {26'd0, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_be_n},
            {26'd0, 4'b0101, ~m});
      check(mem_addr == a, "R3", "read address", 32'(mem_addr), 32'(a));
      ev = expect_rd(a, m);
      n = 1;
      while (!rd_valid && n < 40) begin @(negedge clk); n++; end
      check(n == RDC + 1, "R4", "read latency", 32'(n), 32'(RDC + 1));
      check(rd_data == ev, "R9", "read data", 32'(rd_data), 32'(ev));
      @(negedge clk);
      check(rd_valid == 1'b0, "R4", "single pulse", 32'(rd_valid), 32'd0);
    end else begin
      check(req_ready == 1'b0, "R2", "busy during write", 32'(req_ready), 32'd0);
      check({mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe} ==
            {1'b0, 1'b1, 1'b1, 1'b0, ~m, 1'b1}, "R5", "write pins",
            {26'd0, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_be_n},
            {26'd0, 4'b0110, ~m});
      check(mem_dq_out == d, "R5", "write data", 32'(mem_dq_out), 32'(d));
      n = 1;
      while (!mem_we_n && n < 40) begin @(negedge clk); n++; end
      check(n == WEC + 1, "R5", "we low cycles", 32'(n - 1), 32'(WEC));
      check(!mem_ce1_n && mem_ce2 && mem_dq_oe && mem_be_n == ~m, "R6", "held after we",
            {29'd0, mem_ce1_n, mem_ce2, mem_dq_oe}, 32'd3);
      n = 0;
      while (!mem_ce1_n && n < 40) begin @(negedge clk); n++; end
      check(n == RECC, "R6", "recovery cycles", 32'(n), 32'(RECC));
      check(!mem_dq_oe && (&mem_be_n), "R6", "released together",
            {30'd0, mem_dq_oe, &mem_be_n}, 32'd1);
      w = ref_mem.exists(a) ? ref_mem[a] : 16'h0000;
      if (m[0]) w[7:0]  = d[7:0];
      if (m[1]) w[15:8] = d[15:8];
      ref_mem[a] = w;
    end
  endtask

  initial begin
    #(200000 * PER);
    check(1'b0, "R2", "watchdog expired", 32'd1, 32'd0);
    report();
  end

  initial begin
    logic [AW-1:0] a;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check({mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe, req_ready} ==
          {1'b1, 1'b0, 1'b1, 1'b1, 2'b11, 1'b0, 1'b1}, "R1", "reset pins",
          {24'd0, mem_ce1_n, mem_ce2, mem_oe_n, mem_we_n, mem_be_n, mem_dq_oe, req_ready},
          32'b1011_1101);
    rst = 0;
    @(negedge clk);
    check(req_ready == 1'b1, "R1", "ready after reset", 32'(req_ready), 32'd1);

    // Directed corners: address extremes, single lanes, read right after write, zero masks.
    do_req(1, 19'h7FFFF, 16'hBEEF, 2'b11);
    do_req(0, 19'h7FFFF, 16'h0000, 2'b11);
    do_req(1, 19'h00000, 16'h1234, 2'b01);
    do_req(1, 19'h00000, 16'hAB00, 2'b10);
    do_req(0, 19'h00000, 16'h0000, 2'b11);
    do_req(0, 19'h00000, 16'h0000, 2'b01);
    do_req(0, 19'h00000, 16'h0000, 2'b10);
    do_req(1, 19'h00000, 16'hFFFF, 2'b00);
    do_req(0, 19'h00000, 16'h0000, 2'b00);
    do_req(0, 19'h00000, 16'h0000, 2'b11);
    do_req(1, 19'h00005, 16'h0F0F, 2'b11);

    for (int i = 0; i < 300; i++) begin
      a = ($urandom % 5 == 0) ? 19'h7FFFF : AW'($urandom % 12);
      do_req(1'($urandom % 2), a, 16'($urandom), 2'($urandom % 4));
    end
    report();
  end

endmodule